// File: doc/BRIEF.md
# 8-bit Logic, Shift and Bit-Test Unit

This execution unit serves an 8-bit accumulator processor. On a one-cycle start pulse it samples an operation code, the accumulator, an operand byte, the current status flags and a target select. One clock later it presents the new accumulator value, a memory write-back byte with its write strobe, the updated flags and a one-cycle done pulse. It covers the bitwise logic operations, shifts and rotates through carry, and three kinds of bit test. Address generation, instruction decode, bus timing and arithmetic stay with the surrounding core.

The four flags travel as one 4-bit vector: bit 3 is N (negative), bit 2 is V (overflow), bit 1 is Z (zero) and bit 0 is C (carry). Operation codes are: 0 AND, 1 XOR, 2 OR, 3 shift-left, 4 shift-right, 5 rotate-left, 6 rotate-right, 7 full bit-test, 8 immediate bit-test, 9 test-and-reset, 10 test-and-set. Codes 11 to 15 are unused. The target select is 0 for the accumulator and 1 for memory, and it matters only to the shifts and rotates. When the target is memory, those operations take the operand byte as their source.

Top module: `bitu_top`

## Requirements
- R1: AND (0), XOR (1) and OR (2) combine accumulator and operand into the accumulator. They set N from result bit 7 and Z when the result is zero, keep V and C, and never strobe a write.
- R2: Shift-left (3) moves the source left with a zero fill and puts old bit 7 into C. Shift-right (4) moves it right with a zero fill and puts old bit 0 into C. Both set N and Z from the result and keep V.
- R3: Rotate-left (5) shifts C into bit 0 and old bit 7 into C. Rotate-right (6) shifts C into bit 7 and old bit 0 into C. Both set N and Z from the result and keep V.
- R4: For codes 3 to 6, target 0 uses the accumulator as source and result, and holds mem_we low. Target 1 uses the operand as source, leaves the accumulator output equal to acc_in, drives the result on mem_out and raises mem_we.
- R5: Full bit-test (7) sets N from operand bit 7, V from operand bit 6, and Z when accumulator AND operand is zero. It keeps C, passes the accumulator unchanged and writes nothing.
- R6: Immediate bit-test (8) updates only Z, by the same rule as R5. N, V and C keep their input values.
- R7: Test-and-reset (9) sets Z from accumulator AND operand and keeps N, V and C. It writes back the operand AND the inverted accumulator, with mem_we high.
- R8: Test-and-set (10) sets Z by the same rule as R7 and keeps N, V and C. It writes back the operand OR the accumulator, with mem_we high.
- R9: Unused codes 11 to 15 pass accumulator and flags through unchanged and hold mem_we low. mem_out is 0 whenever mem_we is low after a start.
- R10: Results appear on the clock after the start pulse, together with a one-cycle done pulse. Without start, done and mem_we are low and acc_out, mem_out and flags_out hold their values.
- R11: A synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Sample inputs and execute this cycle |
| op | input | 4 | Operation code |
| acc_in | input | 8 | Current accumulator |
| opnd | input | 8 | Operand or memory byte |
| flags_in | input | 4 | Current flags {N,V,Z,C} |
| to_mem | input | 1 | Shift/rotate target: 0 accumulator, 1 memory |
| acc_out | output | 8 | New accumulator value |
| mem_out | output | 8 | Memory write-back byte |
| mem_we | output | 1 | Memory write strobe |
| flags_out | output | 4 | New flags {N,V,Z,C} |
| done | output | 1 | Result valid pulse |

## Verification
Two functions fall in the same cycle: the memory write-back and a flag update. This happens in memory-target shifts and rotates, where C, N and Z change while mem_out carries the result and the accumulator must stay untouched, and in test-and-reset and test-and-set, where Z changes while the modified byte is written. Back-to-back start pulses with random codes and target selects bring these cases next to plain accumulator operations. A behavioural model checks every output on every cycle, so a write strobe, accumulator value or flag that leaks between neighbouring operations is caught in the cycle it appears.

// File: rtl/bitu_pkg.sv
package bitu_pkg;
    localparam int DW = 8;
    localparam int FW = 4;
    localparam int FN = 3;
    localparam int FV = 2;
    localparam int FZ = 1;
    localparam int FC = 0;

    typedef enum logic [3:0] {
        OP_AND  = 4'd0,
        OP_XOR  = 4'd1,
        OP_OR   = 4'd2,
        OP_SHL  = 4'd3,
        OP_SHR  = 4'd4,
        OP_ROL  = 4'd5,
        OP_ROR  = 4'd6,
        OP_TST  = 4'd7,
        OP_TSTI = 4'd8,
        OP_TRST = 4'd9,
        OP_TSET = 4'd10
    } bitu_op_e;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] mem;
        logic          we;
        logic [FW-1:0] flags;
        logic          done;
    } bitu_state_t;
endpackage

// File: rtl/bitu_logic.sv
module bitu_logic #(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    import bitu_pkg::*;

    always_comb begin
        case (bitu_op_e'(op))
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_OR:   res = a | b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/bitu_shift.sv
module bitu_shift #(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] src,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    import bitu_pkg::*;

    localparam int MSB = W - 1;

    always_comb begin
        res  = src;
        cout = cin;
        case (bitu_op_e'(op))
            OP_SHL: begin
                res  = {src[MSB-1:0], 1'b0};
                cout = src[MSB];
            end
            OP_SHR: begin
                res  = {1'b0, src[MSB:1]};
                cout = src[0];
            end
            OP_ROL: begin
                res  = {src[MSB-1:0], cin};
                cout = src[MSB];
            end
            OP_ROR: begin
                res  = {cin, src[MSB:1]};
                cout = src[0];
            end
            default: begin
                res  = src;
                cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/bitu_test.sv
module bitu_test #(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mem,
    input  logic [3:0]   flags_in,
    output logic [3:0]   flags_out,
    output logic [W-1:0] wb,
    output logic         wb_en
);
    import bitu_pkg::*;

    logic zero;
    assign zero = ((acc & mem) == '0);

    always_comb begin
        flags_out = flags_in;
        wb        = '0;
        wb_en     = 1'b0;
        case (bitu_op_e'(op))
            OP_TST: begin
                flags_out[FN] = mem[W-1];
                flags_out[FV] = mem[W-2];
                flags_out[FZ] = zero;
            end
            OP_TSTI: begin
                flags_out[FZ] = zero;
            end
            OP_TRST: begin
                flags_out[FZ] = zero;
                wb            = mem & ~acc;
                wb_en         = 1'b1;
            end
            OP_TSET: begin
                flags_out[FZ] = zero;
                wb            = mem | acc;
                wb_en         = 1'b1;
            end
            default: begin
                flags_out = flags_in;
            end
        endcase
    end
endmodule

// File: rtl/bitu_top.sv
module bitu_top (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [3:0] op,
    input  logic [7:0] acc_in,
    input  logic [7:0] opnd,
    input  logic [3:0] flags_in,
    input  logic       to_mem,
    output logic [7:0] acc_out,
    output logic [7:0] mem_out,
    output logic       mem_we,
    output logic [3:0] flags_out,
    output logic       done
);
    import bitu_pkg::*;

    localparam int W = DW;

    bitu_state_t cur_q, nx_d;

    logic [W-1:0] logic_res;
    logic [W-1:0] sh_src, sh_res;
    logic         sh_cout;
    logic [3:0]   tst_flags;
    logic [W-1:0] tst_wb;
    logic         tst_wb_en;

    assign sh_src = to_mem ? opnd : acc_in;

    bitu_logic #(.W(W)) u_logic (
        .op  (op),
        .a   (acc_in),
        .b   (opnd),
        .res (logic_res)
    );

    bitu_shift #(.W(W)) u_shift (
        .op   (op),
        .src  (sh_src),
        .cin  (flags_in[FC]),
        .res  (sh_res),
        .cout (sh_cout)
    );

    bitu_test #(.W(W)) u_test (
        .op        (op),
        .acc       (acc_in),
        .mem       (opnd),
        .flags_in  (flags_in),
        .flags_out (tst_flags),
        .wb        (tst_wb),
        .wb_en     (tst_wb_en)
    );

    always_comb begin
        nx_d      = cur_q;
        nx_d.done = 1'b0;
        nx_d.we   = 1'b0;
        if (start) begin
            nx_d.done  = 1'b1;
            nx_d.acc   = acc_in;
            nx_d.mem   = '0;
            nx_d.flags = flags_in;
            case (bitu_op_e'(op))
                OP_AND, OP_XOR, OP_OR: begin
                    nx_d.acc       = logic_res;
                    nx_d.flags[FN] = logic_res[W-1];
                    nx_d.flags[FZ] = (logic_res == '0);
                end
                OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                    if (to_mem) begin
                        nx_d.mem = sh_res;
                        nx_d.we  = 1'b1;
                    end else begin
                        nx_d.acc = sh_res;
                    end
                    nx_d.flags[FN] = sh_res[W-1];
                    nx_d.flags[FZ] = (sh_res == '0);
                    nx_d.flags[FC] = sh_cout;
                end
                OP_TST, OP_TSTI, OP_TRST, OP_TSET: begin
                    nx_d.flags = tst_flags;
                    nx_d.mem   = tst_wb;
                    nx_d.we    = tst_wb_en;
                end
                default: begin
                    nx_d.acc = acc_in;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nx_d;
    end

    assign acc_out   = cur_q.acc;
    assign mem_out   = cur_q.mem;
    assign mem_we    = cur_q.we;
    assign flags_out = cur_q.flags;
    assign done      = cur_q.done;
endmodule

// File: rtl/bitu_chk.sv
module bitu_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [3:0] op,
    input logic [7:0] acc_in,
    input logic [7:0] opnd,
    input logic [3:0] flags_in,
    input logic       to_mem,
    input logic [7:0] acc_out,
    input logic [7:0] mem_out,
    input logic       mem_we,
    input logic [3:0] flags_out,
    input logic       done
);
    // R11: reset clears all outputs
    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (acc_out == 8'h00 && mem_out == 8'h00 && !mem_we && flags_out == 4'h0 && !done));

    // R10: done follows start by one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!done && !mem_we && $stable(acc_out) && $stable(flags_out) && $stable(mem_out)));

    // R1: logic ops never write memory and keep V, C
    a_r1_logic_no_write: assert property (@(posedge clk) disable iff (rst)
        (start && op <= 4'd2) |=> (!mem_we && flags_out[2] == $past(flags_in[2]) && flags_out[0] == $past(flags_in[0])));

    // R4: memory-target shift leaves accumulator untouched
    a_r4_mem_target: assert property (@(posedge clk) disable iff (rst)
        (start && to_mem && op >= 4'd3 && op <= 4'd6) |=> (mem_we && acc_out == $past(acc_in)));

    // R5: full test passes accumulator and copies operand bits to N, V
    a_r5_full_test: assert property (@(posedge clk) disable iff (rst)
        (start && op == 4'd7) |=> (acc_out == $past(acc_in) && flags_out[3] == $past(opnd[7]) && flags_out[2] == $past(opnd[6]) && !mem_we));

    // R6: immediate test keeps N, V, C
    a_r6_imm_keep: assert property (@(posedge clk) disable iff (rst)
        (start && op == 4'd8) |=> (flags_out[3] == $past(flags_in[3]) && flags_out[2] == $past(flags_in[2]) && flags_out[0] == $past(flags_in[0])));

    // R7: test-and-reset write-back
    a_r7_reset_wb: assert property (@(posedge clk) disable iff (rst)
        (start && op == 4'd9) |=> (mem_we && mem_out == ($past(opnd) & ~$past(acc_in))));

    // R8: test-and-set write-back
    a_r8_set_wb: assert property (@(posedge clk) disable iff (rst)
        (start && op == 4'd10) |=> (mem_we && mem_out == ($past(opnd) | $past(acc_in))));

    // R9: unused codes change nothing
    a_r9_unused: assert property (@(posedge clk) disable iff (rst)
        (start && op >= 4'd11) |=> (!mem_we && acc_out == $past(acc_in) && flags_out == $past(flags_in)));
endmodule

bind bitu_top bitu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op        (op),
    .acc_in    (acc_in),
    .opnd      (opnd),
    .flags_in  (flags_in),
    .to_mem    (to_mem),
    .acc_out   (acc_out),
    .mem_out   (mem_out),
    .mem_we    (mem_we),
    .flags_out (flags_out),
    .done      (done)
);

// File: tb/tb_bitu_top.sv
module tb_bitu_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] opnd = '0;
    logic [3:0] flags_in = '0;
    logic       to_mem = 1'b0;
    logic [7:0] acc_out, mem_out;
    logic       mem_we, done;
    logic [3:0] flags_out;

    int n_tests = 0;
    int n_fail  = 0;

    bitu_top dut (
        .clk(clk), .rst(rst), .start(start), .op(op), .acc_in(acc_in),
        .opnd(opnd), .flags_in(flags_in), .to_mem(to_mem),
        .acc_out(acc_out), .mem_out(mem_out), .mem_we(mem_we),
        .flags_out(flags_out), .done(done)
    );

    always #5 clk = ~clk;

    // reference model state
    int    e_acc = 0, e_mem = 0, e_we = 0, e_fl = 0, e_done = 0;
    string e_tag = "R11";

    function automatic string tag_of(int code, bit tm);
        if (code <= 2)                 return "R1";
        if (code == 3 || code == 4)    return tm ? "R4" : "R2";
        if (code == 5 || code == 6)    return tm ? "R4" : "R3";
        if (code == 7)                 return "R5";
        if (code == 8)                 return "R6";
        if (code == 9)                 return "R7";
        if (code == 10)                return "R8";
        return "R9";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            e_acc = 0; e_mem = 0; e_we = 0; e_fl = 0; e_done = 0; e_tag = "R11";
        end else if (!start) begin
            e_done = 0; e_we = 0; e_tag = "R10";
        end else begin
            int a, b, n, v, z, c, r, src, code;
            a = acc_in; b = opnd; code = op;
            n = flags_in[3]; v = flags_in[2]; z = flags_in[1]; c = flags_in[0];
            e_done = 1; e_we = 0; e_mem = 0; e_acc = a;
            e_tag = tag_of(code, to_mem);
            src = to_mem ? b : a;
            if (code <= 2) begin
                r = (code == 0) ? (a & b) : (code == 1) ? (a ^ b) : (a | b);
                e_acc = r; n = r / 128; z = (r == 0);
            end else if (code <= 6) begin
                case (code)
                    3: begin r = (src * 2) % 256; c = src / 128; end
                    4: begin r = src / 2; c = src % 2; end
                    5: begin r = (src * 2) % 256 + c; c = src / 128; end
                    default: begin r = src / 2 + c * 128; c = src % 2; end
                endcase
                n = r / 128; z = (r == 0);
                if (to_mem) begin e_mem = r; e_we = 1; end
                else e_acc = r;
            end else if (code <= 10) begin
                z = ((a & b) == 0);
                if (code == 7) begin n = (b / 128) % 2; v = (b / 64) % 2; end
                if (code == 9)  begin e_mem = b & (255 - a); e_we = 1; end
                if (code == 10) begin e_mem = b | a; e_we = 1; end
            end
            e_fl = n * 8 + v * 4 + z * 2 + c;
        end
    end

    task automatic check(string req, string what, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst || e_tag == "R11") begin
            check("R10", "done", done, e_done);
            check(e_tag, "acc_out", acc_out, e_acc);
            check(e_tag, "mem_out", mem_out, e_mem);
            check(e_tag, "mem_we", mem_we, e_we);
            check(e_tag, "flags_out", flags_out, e_fl);
        end
    end

    task automatic go(int code, int a, int b, int fl, bit tm);
        @(negedge clk);
        #1;
        start = 1'b1; op = code[3:0]; acc_in = a[7:0]; opnd = b[7:0];
        flags_in = fl[3:0]; to_mem = tm;
        @(negedge clk);
        #1;
        start = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        // R1 directed
        go(0, 5, 4, 0, 0);
        go(1, 5, 4, 4'hF, 0);
        go(2, 5, 10, 0, 0);
        // R2 shift-right values, accumulator and memory target (R4)
        go(4, 0, 5, 0, 0);
        go(4, 5, 0, 0, 0);
        go(4, 77, 11, 0, 1);
        go(3, 22, 0, 0, 0);
        // R3 rotates
        go(6, 64, 0, 1, 0);
        go(5, 33, 128, 0, 1);
        go(5, 8, 0, 0, 0);
        // R5 full test
        go(7, 5, 129, 0, 0);
        go(7, 5, 193, 0, 0);
        go(7, 5, 0, 4'hF, 0);
        // R6 immediate test keeps N, V
        go(8, 63, 123, 4'hC, 0);
        go(8, 4, 123, 4'hC, 0);
        // R7 / R8
        go(9, 6, 3, 0, 0);
        go(9, 9, 2, 0, 0);
        go(10, 9, 123, 4'h5, 1);
        // R9 unused code
        go(12, 99, 200, 4'hA, 1);
        // back-to-back random operations
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #1;
            start    = ($urandom % 4) != 0;
            op       = 4'($urandom % 16);
            acc_in   = 8'($urandom);
            opnd     = 8'($urandom);
            flags_in = 4'($urandom);
            to_mem   = 1'($urandom);
            if (i == 1500) rst = 1'b1;
            if (i == 1502) rst = 1'b0;
        end
        @(negedge clk);
        #1 start = 1'b0;
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule